// File: doc/BRIEF.md
# Multi-channel thermal alarm controller

This block scans seven temperature-sensor channels on its own and watches each one against two limits. After a programmable number of clock cycles it asks each enabled channel for a sample. It asks in ascending channel order and has at most one request open at a time. It keeps the newest 9-bit code of every channel. A higher code means a hotter die: about 285 is 25 °C, 350 is 85 °C and 395 is 125 °C.

Every new code is checked against two per-channel limits: an alarm limit and a shutdown limit. A channel counts as over a limit when its code is greater than or equal to that limit. Each check must see a run of over-limit samples before it fires, and any sample under the limit resets the run. A fired alarm sets a pending bit, and the enabled pending bits drive the interrupt. A fired shutdown sets its own pending bit and then drives a shutdown pin, a reset-controller request, or both, depending on how that channel is routed. The shutdown pin has a selectable polarity.

Software programs the block through a flat register bus. Writes to the enable and control registers carry a per-bit write-enable mask in bits 31:16.

Top module: `thermal_alarm_ctrl`

## Requirements
- R1: After reset the block is in the following state. Scan is off, the polarity is active low, and all enables and routes are 0. Both periods are 5000 and both run lengths are 4. Every alarm limit is 511 and every shutdown limit is 361, which is about 95 °C. No request is raised, `irq` and `shut_rst` are 0, and `shut_pin` is 1.
- R2: The register byte addresses are as follows. 0x00 is control: bit 0 is scan enable, bit 8 is shutdown polarity. 0x04 is channel enable, 0x08 alarm-interrupt enable, 0x0C shutdown-check enable, 0x10 pin route and 0x14 reset route, each with bit n for channel n. In these six registers, bit n (n < 16) changes only when bit n+16 of the same write is 1.
- R3: The remaining registers are as follows. 0x18 is alarm pending and 0x1C is shutdown pending. 0x20 is the normal period and 0x24 the high-temperature period, in bits 15:0. 0x28 is the alarm run length and 0x2C the shutdown run length, in bits 7:0. Per channel c there is a sample code at 0x40+4c (read only), an alarm limit at 0x80+4c and a shutdown limit at 0xC0+4c, each in bits 8:0.
- R4: The scan requests channels in ascending index order and skips disabled ones. `smp_req` is one-hot with at most one bit set. A request stays unchanged until `smp_valid` is seen with it.
- R5: A round of requests starts exactly P clock edges after the edge that enables scanning. P is the normal period while no alarm is pending, and the high-temperature period while any alarm pending bit is set.
- R6: The code delivered with `smp_valid` is stored as that channel's sample code.
- R7: The alarm pending bit of a channel is set on the sample that completes a run of N consecutive samples at or above its alarm limit. N is the run length, and 0 is taken as 1. A sample below the limit restarts the run. A run longer than N does not count again.
- R8: The pending bits are cleared by writing 1 to them, and a set in the same cycle wins over a clear. `irq` is the OR of the alarm pending bits whose interrupt enable is 1.
- R9: The shutdown check follows the same rule with the shutdown limit and the shutdown run length, but only for channels whose shutdown-check enable is 1. A disabled channel restarts its run.
- R10: `shut_rst` is 1 while any shutdown pending bit is set on a channel with reset route 1. The shutdown pin is active while any shutdown pending bit is set on a channel with pin route 1.
- R11: Control bit 8 = 1 makes `shut_pin` active high. Bit 8 = 0 makes it active low, so the pin is 1 when idle.
- R12: Once asserted, the shutdown outputs stay asserted even after the codes fall. They are released only by reset or by clearing the matching pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Write data, masks in bits 31:16 where used |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| smp_req | output | 7 | One-hot sample request per channel |
| smp_valid | input | 1 | Sample on `smp_code` is valid for the requested channel |
| smp_code | input | 9 | Sensor code |
| irq | output | 1 | Alarm interrupt |
| shut_pin | output | 1 | Shutdown pin, polarity set by control bit 8 |
| shut_rst | output | 1 | Shutdown request to the reset controller |

## Verification
The hardest case to reach from the ports is the switch to the high-temperature period. An alarm has to be pending before a scan is enabled, and then the bench must count the exact edges up to the first request. The bench first lets a single channel fire an alarm with run length 1. It then times the next round, expecting the short period, after timing a round under the normal period with nothing pending. Runs that cross a limit and then fall back are produced by drawing each round's codes within a few codes of the limits. The run lengths and routes are reprogrammed while partial runs are still held in the counters.

// File: rtl/thermal_alarm_pkg.sv
package thermal_alarm_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CHEN  = 8'h04;
  localparam logic [ADDR_W-1:0] A_ALEN  = 8'h08;
  localparam logic [ADDR_W-1:0] A_SHEN  = 8'h0C;
  localparam logic [ADDR_W-1:0] A_PINRT = 8'h10;
  localparam logic [ADDR_W-1:0] A_RSTRT = 8'h14;
  localparam logic [ADDR_W-1:0] A_ALP   = 8'h18;
  localparam logic [ADDR_W-1:0] A_SHP   = 8'h1C;
  localparam logic [ADDR_W-1:0] A_PER   = 8'h20;
  localparam logic [ADDR_W-1:0] A_PERHT = 8'h24;
  localparam logic [ADDR_W-1:0] A_DEBA  = 8'h28;
  localparam logic [ADDR_W-1:0] A_DEBS  = 8'h2C;
  localparam logic [1:0] R_DATA = 2'b01;
  localparam logic [1:0] R_ATHR = 2'b10;
  localparam logic [1:0] R_STHR = 2'b11;

  typedef enum logic {SC_IDLE, SC_BUSY} scan_state_e;

  function automatic logic [15:0] mask_wr(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction
endpackage

// File: rtl/tac_debounce.sv
module tac_debounce #(
  parameter int CODE_W = 9,
  parameter int DEB_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd,
  input  logic              en,
  input  logic [CODE_W-1:0] code,
  input  logic [CODE_W-1:0] thr,
  input  logic [DEB_W-1:0]  deb,
  output logic              fire
);
  logic [DEB_W-1:0] cnt_q, cnt_nxt, eff;
  logic             over;

  always_comb begin
    eff     = (deb == '0) ? DEB_W'(1) : deb;
    over    = (code >= thr);
    cnt_nxt = cnt_q;
    fire    = 1'b0;
    if (!en) begin
      cnt_nxt = '0;
    end else if (upd) begin
      if (!over) begin
        cnt_nxt = '0;
      end else if (cnt_q < eff) begin
        cnt_nxt = cnt_q + DEB_W'(1);
        fire    = (cnt_q + DEB_W'(1) == eff);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end
endmodule

// File: rtl/tac_scan.sv
module tac_scan #(
  parameter int NCH   = 7,
  parameter int PER_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic [NCH-1:0]   ch_en,
  input  logic [PER_W-1:0] period,
  input  logic             smp_valid,
  output logic [NCH-1:0]   smp_req
);
  import thermal_alarm_pkg::*;
  localparam int IDX_W = (NCH > 1) ? $clog2(NCH) : 1;

  scan_state_e      st_q, st_nxt;
  logic [PER_W-1:0] tmr_q, tmr_nxt;
  logic [IDX_W-1:0] cur_q, cur_nxt;

  always_comb begin
    st_nxt  = st_q;
    tmr_nxt = tmr_q;
    cur_nxt = cur_q;
    if (st_q == SC_IDLE) begin
      if (!scan_en) begin
        tmr_nxt = '0;
      end else if ({1'b0, tmr_q} + (PER_W+1)'(1) >= {1'b0, period}) begin
        tmr_nxt = '0;
        cur_nxt = '0;
        st_nxt  = SC_BUSY;
      end else begin
        tmr_nxt = tmr_q + PER_W'(1);
      end
    end else if (!ch_en[cur_q] || smp_valid) begin
      if (cur_q == IDX_W'(NCH-1)) st_nxt = SC_IDLE;
      else                        cur_nxt = cur_q + IDX_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SC_IDLE;
      tmr_q <= '0;
      cur_q <= '0;
    end else begin
      st_q  <= st_nxt;
      tmr_q <= tmr_nxt;
      cur_q <= cur_nxt;
    end
  end

  assign smp_req = (st_q == SC_BUSY && ch_en[cur_q]) ? (NCH'(1) << cur_q) : '0;

  // R4
  req_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(smp_req));

  // R4
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|smp_req && !smp_valid) |=> ($stable(smp_req) || !$stable(ch_en)));
endmodule

// File: rtl/tac_regs.sv
module tac_regs #(
  parameter int NCH          = 7,
  parameter int CODE_W       = 9,
  parameter int PER_W        = 16,
  parameter int DEB_W        = 8,
  parameter int PERIOD_RST   = 5000,
  parameter int DEB_RST      = 4,
  parameter int SHUT_THR_RST = 361
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         wr_en,
  input  logic [7:0]                   addr,
  input  logic [31:0]                  wdata,
  output logic [31:0]                  rdata,
  input  logic [NCH-1:0]               upd,
  input  logic [CODE_W-1:0]            code,
  input  logic [NCH-1:0]               al_fire,
  input  logic [NCH-1:0]               sh_fire,
  output logic                         scan_en,
  output logic                         pol,
  output logic [NCH-1:0]               ch_en,
  output logic [NCH-1:0]               al_en,
  output logic [NCH-1:0]               sh_en,
  output logic [NCH-1:0]               pin_rt,
  output logic [NCH-1:0]               rst_rt,
  output logic [NCH-1:0]               al_pend,
  output logic [NCH-1:0]               sh_pend,
  output logic [PER_W-1:0]             period,
  output logic [PER_W-1:0]             period_ht,
  output logic [DEB_W-1:0]             deb_al,
  output logic [DEB_W-1:0]             deb_sh,
  output logic [NCH-1:0][CODE_W-1:0]   thr_al,
  output logic [NCH-1:0][CODE_W-1:0]   thr_sh
);
  import thermal_alarm_pkg::*;

  logic                       scan_nxt, pol_nxt;
  logic [NCH-1:0]             chen_nxt, alen_nxt, shen_nxt, pin_nxt, rst_nxt;
  logic [NCH-1:0]             alp_nxt, shp_nxt, al_clr, sh_clr;
  logic [PER_W-1:0]           per_nxt, perht_nxt;
  logic [DEB_W-1:0]           deba_nxt, debs_nxt;
  logic [NCH-1:0][CODE_W-1:0] thra_nxt, thrs_nxt, data_q, data_nxt;
  logic [15:0]                t;
  logic [3:0]                 idx;
  logic                       idx_ok;

  assign idx    = addr[5:2];
  assign idx_ok = int'(idx) < NCH;

  always_comb begin
    scan_nxt = scan_en;   pol_nxt  = pol;
    chen_nxt = ch_en;     alen_nxt = al_en;   shen_nxt = sh_en;
    pin_nxt  = pin_rt;    rst_nxt  = rst_rt;
    per_nxt  = period;    perht_nxt = period_ht;
    deba_nxt = deb_al;    debs_nxt = deb_sh;
    thra_nxt = thr_al;    thrs_nxt = thr_sh;
    al_clr   = '0;        sh_clr   = '0;
    t        = '0;
    if (wr_en) begin
      case (addr)
        A_CTRL: begin
          t = mask_wr({7'b0, pol, 7'b0, scan_en}, wdata);
          scan_nxt = t[0];
          pol_nxt  = t[8];
        end
        A_CHEN:  chen_nxt  = NCH'(mask_wr(16'(ch_en), wdata));
        A_ALEN:  alen_nxt  = NCH'(mask_wr(16'(al_en), wdata));
        A_SHEN:  shen_nxt  = NCH'(mask_wr(16'(sh_en), wdata));
        A_PINRT: pin_nxt   = NCH'(mask_wr(16'(pin_rt), wdata));
        A_RSTRT: rst_nxt   = NCH'(mask_wr(16'(rst_rt), wdata));
        A_ALP:   al_clr    = wdata[NCH-1:0];
        A_SHP:   sh_clr    = wdata[NCH-1:0];
        A_PER:   per_nxt   = wdata[PER_W-1:0];
        A_PERHT: perht_nxt = wdata[PER_W-1:0];
        A_DEBA:  deba_nxt  = wdata[DEB_W-1:0];
        A_DEBS:  debs_nxt  = wdata[DEB_W-1:0];
        default: begin
          if (idx_ok && addr[7:6] == R_ATHR) thra_nxt[idx] = wdata[CODE_W-1:0];
          if (idx_ok && addr[7:6] == R_STHR) thrs_nxt[idx] = wdata[CODE_W-1:0];
        end
      endcase
    end
    alp_nxt = (al_pend & ~al_clr) | al_fire;
    shp_nxt = (sh_pend & ~sh_clr) | sh_fire;
    for (int c = 0; c < NCH; c++) begin
      data_nxt[c] = upd[c] ? code : data_q[c];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scan_en <= 1'b0;  pol <= 1'b0;
      ch_en <= '0; al_en <= '0; sh_en <= '0; pin_rt <= '0; rst_rt <= '0;
      al_pend <= '0; sh_pend <= '0;
      period <= PER_W'(PERIOD_RST);  period_ht <= PER_W'(PERIOD_RST);
      deb_al <= DEB_W'(DEB_RST);     deb_sh <= DEB_W'(DEB_RST);
      thr_al <= '1;
      thr_sh <= {NCH{CODE_W'(SHUT_THR_RST)}};
      data_q <= '0;
    end else begin
      scan_en <= scan_nxt;  pol <= pol_nxt;
      ch_en <= chen_nxt; al_en <= alen_nxt; sh_en <= shen_nxt;
      pin_rt <= pin_nxt; rst_rt <= rst_nxt;
      al_pend <= alp_nxt; sh_pend <= shp_nxt;
      period <= per_nxt; period_ht <= perht_nxt;
      deb_al <= deba_nxt; deb_sh <= debs_nxt;
      thr_al <= thra_nxt; thr_sh <= thrs_nxt;
      data_q <= data_nxt;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata = {23'b0, pol, 7'b0, scan_en};
      A_CHEN:  rdata = 32'(ch_en);
      A_ALEN:  rdata = 32'(al_en);
      A_SHEN:  rdata = 32'(sh_en);
      A_PINRT: rdata = 32'(pin_rt);
      A_RSTRT: rdata = 32'(rst_rt);
      A_ALP:   rdata = 32'(al_pend);
      A_SHP:   rdata = 32'(sh_pend);
      A_PER:   rdata = 32'(period);
      A_PERHT: rdata = 32'(period_ht);
      A_DEBA:  rdata = 32'(deb_al);
      A_DEBS:  rdata = 32'(deb_sh);
      default: begin
        if (idx_ok && addr[7:6] == R_DATA) rdata = 32'(data_q[idx]);
        if (idx_ok && addr[7:6] == R_ATHR) rdata = 32'(thr_al[idx]);
        if (idx_ok && addr[7:6] == R_STHR) rdata = 32'(thr_sh[idx]);
      end
    endcase
  end

  // R12
  shut_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == A_SHP) |=> (($past(sh_pend) & ~sh_pend) == '0));
endmodule

// File: rtl/thermal_alarm_ctrl.sv
module thermal_alarm_ctrl #(
  parameter int NCH    = 7,
  parameter int CODE_W = 9,
  parameter int PER_W  = 16,
  parameter int DEB_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [NCH-1:0]    smp_req,
  input  logic              smp_valid,
  input  logic [CODE_W-1:0] smp_code,
  output logic              irq,
  output logic              shut_pin,
  output logic              shut_rst
);
  logic [1:0]                 rs_q;
  logic                       rst_n_s;
  logic                       scan_en, pol;
  logic [NCH-1:0]             ch_en, al_en, sh_en, pin_rt, rst_rt;
  logic [NCH-1:0]             al_pend, sh_pend, upd, al_fire, sh_fire;
  logic [PER_W-1:0]           period, period_ht, period_act;
  logic [DEB_W-1:0]           deb_al, deb_sh;
  logic [NCH-1:0][CODE_W-1:0] thr_al, thr_sh;
  logic                       pin_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  tac_regs #(.NCH(NCH), .CODE_W(CODE_W), .PER_W(PER_W), .DEB_W(DEB_W)) u_regs (
    .clk(clk), .rst_n(rst_n_s), .wr_en(reg_wr), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .upd(upd), .code(smp_code),
    .al_fire(al_fire), .sh_fire(sh_fire), .scan_en(scan_en), .pol(pol),
    .ch_en(ch_en), .al_en(al_en), .sh_en(sh_en), .pin_rt(pin_rt),
    .rst_rt(rst_rt), .al_pend(al_pend), .sh_pend(sh_pend), .period(period),
    .period_ht(period_ht), .deb_al(deb_al), .deb_sh(deb_sh),
    .thr_al(thr_al), .thr_sh(thr_sh));

  assign period_act = (|al_pend) ? period_ht : period;

  tac_scan #(.NCH(NCH), .PER_W(PER_W)) u_scan (
    .clk(clk), .rst_n(rst_n_s), .scan_en(scan_en), .ch_en(ch_en),
    .period(period_act), .smp_valid(smp_valid), .smp_req(smp_req));

  assign upd = smp_valid ? smp_req : '0;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    tac_debounce #(.CODE_W(CODE_W), .DEB_W(DEB_W)) u_al (
      .clk(clk), .rst_n(rst_n_s), .upd(upd[c]), .en(1'b1), .code(smp_code),
      .thr(thr_al[c]), .deb(deb_al), .fire(al_fire[c]));
    tac_debounce #(.CODE_W(CODE_W), .DEB_W(DEB_W)) u_sh (
      .clk(clk), .rst_n(rst_n_s), .upd(upd[c]), .en(sh_en[c]), .code(smp_code),
      .thr(thr_sh[c]), .deb(deb_sh), .fire(sh_fire[c]));
  end

  assign irq      = |(al_pend & al_en);
  assign pin_act  = |(sh_pend & pin_rt);
  assign shut_pin = pol ? pin_act : ~pin_act;
  assign shut_rst = |(sh_pend & rst_rt);

  // R7
  alarm_on_sample_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(|al_pend) |-> $past(smp_valid));
endmodule

// File: tb/thermal_alarm_ctrl_test.sv
module thermal_alarm_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  smp_req;
  logic        smp_valid = 1'b0;
  logic [8:0]  smp_code = '0;
  logic        irq, shut_pin, shut_rst;

  always #10 clk = ~clk;

  thermal_alarm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_req(smp_req),
    .smp_valid(smp_valid), .smp_code(smp_code), .irq(irq),
    .shut_pin(shut_pin), .shut_rst(shut_rst));

  int nvec = 0, nerr = 0;
  logic [6:0] e_chen = '0, e_alen = '0, e_shen = '0, e_pin = '0, e_rst = '0;
  logic [6:0] e_alp = '0, e_shp = '0, seen = '0;
  logic e_pol = 1'b0;
  int deb_a = 4, deb_s = 4;
  int thra[7], thrs[7], tcode[7], cnta[7], cnts[7], lastd[7];
  int nsamp = 0, last_ch = -1, dly = 0;

  task automatic chk(string tag, int act, int exp);
    nvec++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mw(logic [15:0] old, logic [31:0] w);
    return (old & ~w[31:16]) | (w[15:0] & w[31:16]);
  endfunction

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output int v);
    @(negedge clk);
    reg_addr = a;
    #1 v = int'(reg_rdata);
  endtask

  // expected effect of one sample, from R7 and R9
  task automatic model_sample(int ch, int c);
    int ea, es;
    lastd[ch] = c; seen[ch] = 1'b1;
    ea = (deb_a == 0) ? 1 : deb_a;
    es = (deb_s == 0) ? 1 : deb_s;
    if (c >= thra[ch]) begin
      if (cnta[ch] < ea) begin
        cnta[ch]++;
        if (cnta[ch] == ea) e_alp[ch] = 1'b1;
      end
    end else cnta[ch] = 0;
    if (!e_shen[ch]) cnts[ch] = 0;
    else if (c >= thrs[ch]) begin
      if (cnts[ch] < es) begin
        cnts[ch]++;
        if (cnts[ch] == es) e_shp[ch] = 1'b1;
      end
    end else cnts[ch] = 0;
  endtask

  // behavioural sensor
  always @(negedge clk) begin
    if (smp_valid) smp_valid = 1'b0;
    else if (smp_req != '0) begin
      if (dly == 0) begin
        int ch;
        ch = 0;
        for (int i = 0; i < 7; i++) if (smp_req[i]) ch = i;
        chk("R4 onehot", $countones(smp_req), 1);
        chk("R4 ascending and enabled", int'(ch > last_ch && e_chen[ch]), 1);
        last_ch = ch;
        smp_code = 9'(tcode[ch]);
        smp_valid = 1'b1;
        model_sample(ch, tcode[ch]);
        nsamp++;
        dly = $urandom % 3;
      end else dly--;
    end
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nerr++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    summary();
  end

  // run one scan round; exp_lat > 0 measures edges to the first request (R5)
  task automatic round(int exp_lat, string tag);
    int s, want, n;
    s = nsamp; want = $countones(e_chen); last_ch = -1;
    wr(8'h00, 32'h0001_0001);
    if (exp_lat > 0) begin
      n = 0;
      forever begin
        @(posedge clk); n++;
        @(negedge clk);
        if (smp_req != '0 || n > exp_lat + 5) break;
      end
      chk(tag, n, exp_lat);
    end
    if (want == 0) repeat (80) @(negedge clk);
    while (nsamp - s < want || smp_valid) @(negedge clk);
    repeat (2) @(negedge clk);
    wr(8'h00, 32'h0001_0000);
    chk("R4 sample count", nsamp - s, want);
  endtask

  task automatic check_state();
    int v, act, ch;
    rd(8'h18, v); chk("R7 alarm pending", v, int'(e_alp));
    rd(8'h1C, v); chk("R9 shutdown pending", v, int'(e_shp));
    chk("R8 irq", int'(irq), int'(|(e_alp & e_alen)));
    chk("R10 shut_rst", int'(shut_rst), int'(|(e_shp & e_rst)));
    act = |(e_shp & e_pin);
    chk("R11 R12 shut_pin", int'(shut_pin), e_pol ? act : int'(!act));
    ch = $urandom % 7;
    if (seen[ch]) begin
      rd(8'(8'h40 + 4*ch), v); chk("R6 sample code", v, lastd[ch]);
    end
  endtask

  initial begin
    int v;
    logic [31:0] w;
    void'($urandom(32'd7331));
    for (int c = 0; c < 7; c++) begin
      thra[c] = 511; thrs[c] = 361; tcode[c] = 100;
      cnta[c] = 0; cnts[c] = 0; lastd[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h00, v); chk("R1 control", v, 0);
    rd(8'h04, v); chk("R1 channel enable", v, 0);
    rd(8'h20, v); chk("R1 period", v, 5000);
    rd(8'h24, v); chk("R1 ht period", v, 5000);
    rd(8'h28, v); chk("R1 alarm run", v, 4);
    rd(8'h2C, v); chk("R1 shutdown run", v, 4);
    rd(8'hC0, v); chk("R1 shutdown limit", v, 361);
    rd(8'h98, v); chk("R1 alarm limit", v, 511);
    chk("R1 shut_pin", int'(shut_pin), 1);
    chk("R1 shut_rst", int'(shut_rst), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 request", int'(smp_req), 0);

    // R2 masked writes
    wr(8'h04, 32'h0000_007F);
    rd(8'h04, v); chk("R2 no mask no change", v, 0);
    wr(8'h04, 32'h0005_007F);
    rd(8'h04, v); chk("R2 partial mask", v, 5);
    wr(8'h00, 32'h0100_0101);
    rd(8'h00, v); chk("R2 R11 polarity only", v, 32'h100);
    chk("R11 active high idle", int'(shut_pin), 0);
    wr(8'h00, 32'h0100_0000);
    rd(8'h00, v); chk("R2 polarity cleared", v, 0);
    wr(8'h04, 32'h007F_0001); e_chen = 7'h01;

    // R5 latency, normal then high-temperature period
    wr(8'h20, 40); wr(8'h24, 12); wr(8'h28, 1); deb_a = 1;
    wr(8'h80, 100); thra[0] = 100; tcode[0] = 300;
    rd(8'h24, v); chk("R3 ht period readback", v, 12);
    round(40, "R5 normal period latency");
    check_state();
    chk("R7 run of one", int'(e_alp[0]), 1);
    round(12, "R5 high-temperature period latency");
    wr(8'h18, 32'h7F); e_alp = '0;
    check_state();

    // R12 directed: latch after codes fall
    wr(8'h0C, 32'h0001_0001); e_shen[0] = 1'b1;
    wr(8'h10, 32'h0001_0001); e_pin[0] = 1'b1;
    wr(8'h2C, 1); deb_s = 1; tcode[0] = 400;
    round(40, "R5 normal period again");
    check_state();
    chk("R12 pin asserted", int'(shut_pin), 0);
    tcode[0] = 10;
    round(0, "");
    check_state();
    chk("R12 pin still latched", int'(shut_pin), 0);
    wr(8'h1C, 32'h01); e_shp = '0;
    chk("R12 released by clear", int'(shut_pin), 1);
    wr(8'h18, 32'h7F); e_alp = '0;

    // random rounds
    wr(8'h20, 60); wr(8'h24, 60);
    for (int r = 0; r < 40; r++) begin
      if (r % 8 == 0) begin
        for (int c = 0; c < 7; c++) begin
          thra[c] = 20 + $urandom % 440;
          thrs[c] = thra[c] + $urandom % 4;
          wr(8'(8'h80 + 4*c), 32'(thra[c]));
          wr(8'(8'hC0 + 4*c), 32'(thrs[c]));
        end
      end
      for (int c = 0; c < 7; c++) tcode[c] = thra[c] + ($urandom % 9) - 4;
      w = {9'b0, 7'($urandom), 9'b0, 7'($urandom)};
      wr(8'h04, w); e_chen = 7'(mw(16'(e_chen), w));
      w = {9'b0, 7'($urandom), 9'b0, 7'($urandom)};
      wr(8'h08, w); e_alen = 7'(mw(16'(e_alen), w));
      w = {9'b0, 7'($urandom), 9'b0, 7'($urandom)};
      wr(8'h0C, w); e_shen = 7'(mw(16'(e_shen), w));
      for (int c = 0; c < 7; c++) if (!e_shen[c]) cnts[c] = 0;
      w = {9'b0, 7'($urandom), 9'b0, 7'($urandom)};
      wr(8'h10, w); e_pin = 7'(mw(16'(e_pin), w));
      w = {9'b0, 7'($urandom), 9'b0, 7'($urandom)};
      wr(8'h14, w); e_rst = 7'(mw(16'(e_rst), w));
      if ($urandom % 4 == 0) begin
        e_pol = 1'($urandom);
        wr(8'h00, {16'h0100, 7'b0, e_pol, 8'h00});
      end
      if ($urandom % 3 == 0) begin
        deb_a = $urandom % 4; deb_s = 1 + $urandom % 3;
        wr(8'h28, 32'(deb_a)); wr(8'h2C, 32'(deb_s));
      end
      round(0, "");
      check_state();
      w = 32'(7'($urandom));
      wr(8'h18, w); e_alp = e_alp & ~w[6:0];
      w = 32'(7'($urandom));
      wr(8'h1C, w); e_shp = e_shp & ~w[6:0];
      check_state();
    end
    summary();
  end
endmodule